// File: doc/BRIEF.md
# Address Translation Cache With Invalidation

This block keeps a handful of recently used virtual-to-physical page translations so that a memory access can be translated without consulting the page tables. A lookup is answered combinationally: in the same cycle the block reports whether a stored entry covers the virtual address and, if so, the physical address and the permission bits of that page. When no entry covers the address, the block asks the page table walker for a four-level walk. The walker later hands back the result on the fill port, and the block stores it.

Each stored entry can describe a 4KB, 2MB or 1GB page, so entries compare different numbers of upper address bits and pass a different number of low bits through unchanged. Software keeps the cache coherent with the tables in two ways: a single-address invalidate drops only the entries covering that address, and a write of the root table base register empties the whole cache. A walk that was in flight across such a flush is treated as stale and its result is discarded.

Top module: `tlb_cache`

## Requirements
- R1: While `lk_valid` is high, `lk_hit` is high in the same cycle exactly when a valid entry covers `lk_vaddr`, and `lk_wr`, `lk_usr`, `lk_nx` show that entry's permissions; while `lk_valid` is low, `lk_hit` is low.
- R2: The size code selects the compared bits: 0 (4KB) compares virtual bits 47:12, 1 (2MB) bits 47:21, 2 (1GB) bits 47:30, and code 3 behaves as 4KB. `lk_paddr` takes its bits below the page size from `lk_vaddr` and the rest from the stored frame number placed at bit 12; frame bits below the page size are ignored.
- R3: `walk_req` is high in the same cycle exactly when `lk_valid` is high and no entry covers `lk_vaddr`.
- R4: An accepted fill is visible to lookups from the next cycle on.
- R5: A single-address invalidate clears every entry covering `inv_vaddr` at the next edge; entries that do not cover it keep translating.
- R6: A pulse on `root_wr` clears all entries and returns the replacement pointer to entry 0; the next cycle no lookup hits.
- R7: A fill goes to the first invalid entry found searching cyclically from the replacement pointer; if every entry is valid it goes to the entry at the pointer. The pointer then moves to the entry after the one written.
- R8: A fill in the same cycle as `root_wr` is dropped, and a fill in the same cycle as an invalidate whose address falls in the filled page is dropped; a fill with an invalidate of another page is stored.
- R9: If `root_wr` arrives while a walk is outstanding (a miss seen at a clock edge and no fill since), the next fill is dropped; later fills are stored normally.
- R10: After reset every entry is invalid, the pointer is 0 and no walk is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_hit | output | 1 | An entry covers the lookup address |
| lk_paddr | output | 40 | Translated physical address |
| lk_wr | output | 1 | Page is writable |
| lk_usr | output | 1 | Page is accessible from user mode |
| lk_nx | output | 1 | Page forbids instruction fetch |
| walk_req | output | 1 | Lookup missed; a table walk is wanted |
| fill_valid | input | 1 | Walker delivers a translation |
| fill_vaddr | input | 48 | Virtual address the walk was for |
| fill_frame | input | 28 | Physical frame number (address bits 39:12) |
| fill_size | input | 2 | Page size code: 0 4KB, 1 2MB, 2 1GB, 3 as 4KB |
| fill_wr | input | 1 | Writable bit of the walked page |
| fill_usr | input | 1 | User bit of the walked page |
| fill_nx | input | 1 | No-execute bit of the walked page |
| inv_valid | input | 1 | Invalidate entries covering `inv_vaddr` |
| inv_vaddr | input | 48 | Address to invalidate |
| root_wr | input | 1 | Root table base register written: flush all |

## Verification
On every cycle the assertions check that nothing hits the cycle after a flush, that an address invalidated in the previous cycle does not hit, that the page offset always passes through on a hit, that a missing lookup always raises a walk request and that an idle lookup never hits. The ordering of replacement over invalid and valid entries, the address composition for each page size, the dropping of fills that collide with maintenance in the same cycle, and the discarding of a walk that straddled a flush depend on sequences of fills and lookups, so only the bench's scenarios show them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 48;
    localparam int PA_W  = 40;
    localparam int PG_SH = 12;
    localparam int LVL_W = 9;
    localparam int VPN_W = VA_W - PG_SH;
    localparam int FN_W  = PA_W - PG_SH;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_2M  = 2'd1,
        PG_1G  = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] tag;
        logic [FN_W-1:0]  frame;
        pg_size_e         size;
        logic             wr;
        logic             usr;
        logic             nx;
    } tlb_ent_t;

    // Page-number bits that take part in the compare for a given size.
    function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
        logic [VPN_W-1:0] m;
        m = '1;
        case (s)
            PG_2M:   m[LVL_W-1:0]   = '0;
            PG_1G:   m[2*LVL_W-1:0] = '0;
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic page_covers(logic [VPN_W-1:0] tag, pg_size_e s,
                                         logic [VA_W-1:0] va);
        return ((va[VA_W-1:PG_SH] ^ tag) & vpn_mask(s)) == '0;
    endfunction
endpackage

// File: rtl/tlb_cam_row.sv
module tlb_cam_row
    import tlb_pkg::*;
(
    input  tlb_ent_t        ent,
    input  logic [VA_W-1:0] lk_vaddr,
    input  logic [VA_W-1:0] inv_vaddr,
    output logic            lk_match,
    output logic            inv_match
);
    always_comb begin
        lk_match  = ent.vld && page_covers(ent.tag, ent.size, lk_vaddr);
        inv_match = ent.vld && page_covers(ent.tag, ent.size, inv_vaddr);
    end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] vld,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] victim
);
    logic found;

    always_comb begin
        victim = ptr;
        found  = 1'b0;
        for (int k = 0; k < N_ENT; k++) begin
            int j;
            j = (int'(ptr) + k) % N_ENT;
            if (!found && !vld[j]) begin
                victim = IDX_W'(j);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_vaddr,
    output logic            lk_hit,
    output logic [PA_W-1:0] lk_paddr,
    output logic            lk_wr,
    output logic            lk_usr,
    output logic            lk_nx,
    output logic            walk_req,
    input  logic            fill_valid,
    input  logic [VA_W-1:0] fill_vaddr,
    input  logic [FN_W-1:0] fill_frame,
    input  logic [1:0]      fill_size,
    input  logic            fill_wr,
    input  logic            fill_usr,
    input  logic            fill_nx,
    input  logic            inv_valid,
    input  logic [VA_W-1:0] inv_vaddr,
    input  logic            root_wr
);
    localparam int IDX_W = $clog2(N_ENT);

    typedef struct packed {
        tlb_ent_t [N_ENT-1:0] ent;
        logic [IDX_W-1:0]     ptr;
        logic                 pend;
        logic                 stale;
    } st_t;

    st_t              st_d, st_q;
    logic [N_ENT-1:0] lk_match, inv_match, vld_vec;
    logic [IDX_W-1:0] victim;
    tlb_ent_t         sel;
    logic             any_match;
    logic             fill_ok;

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_row
        tlb_cam_row u_row (
            .ent      (st_q.ent[gi]),
            .lk_vaddr (lk_vaddr),
            .inv_vaddr(inv_vaddr),
            .lk_match (lk_match[gi]),
            .inv_match(inv_match[gi])
        );
        assign vld_vec[gi] = st_q.ent[gi].vld;
    end

    tlb_victim_pick #(.N_ENT(N_ENT)) u_victim (
        .vld   (vld_vec),
        .ptr   (st_q.ptr),
        .victim(victim)
    );

    // Lookup side: lowest-numbered matching entry wins.
    always_comb begin
        any_match = 1'b0;
        sel       = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (lk_match[i]) begin
                any_match = 1'b1;
                sel       = st_q.ent[i];
            end
        end
        lk_hit   = lk_valid && any_match;
        walk_req = lk_valid && !any_match;
        lk_paddr = {sel.frame, lk_vaddr[PG_SH-1:0]};
        if (sel.size == PG_2M)
            lk_paddr[PG_SH+LVL_W-1:PG_SH] = lk_vaddr[PG_SH+LVL_W-1:PG_SH];
        if (sel.size == PG_1G)
            lk_paddr[PG_SH+2*LVL_W-1:PG_SH] = lk_vaddr[PG_SH+2*LVL_W-1:PG_SH];
        lk_wr  = lk_hit && sel.wr;
        lk_usr = lk_hit && sel.usr;
        lk_nx  = lk_hit && sel.nx;
    end

    // Next-state side.
    always_comb begin
        st_d = st_q;

        fill_ok = fill_valid && !root_wr && !st_q.stale &&
                  !(inv_valid && page_covers(fill_vaddr[VA_W-1:PG_SH],
                                             pg_size_e'(fill_size), inv_vaddr));

        for (int i = 0; i < N_ENT; i++) begin
            if (inv_valid && inv_match[i])
                st_d.ent[i].vld = 1'b0;
        end

        if (fill_ok) begin
            st_d.ent[victim].vld   = 1'b1;
            st_d.ent[victim].tag   = fill_vaddr[VA_W-1:PG_SH];
            st_d.ent[victim].frame = fill_frame;
            st_d.ent[victim].size  = pg_size_e'(fill_size);
            st_d.ent[victim].wr    = fill_wr;
            st_d.ent[victim].usr   = fill_usr;
            st_d.ent[victim].nx    = fill_nx;
            st_d.ptr = (victim == IDX_W'(N_ENT - 1)) ? '0 : victim + 1'b1;
        end

        if (fill_valid) begin
            st_d.pend  = 1'b0;
            st_d.stale = 1'b0;
        end
        if (walk_req)
            st_d.pend = 1'b1;

        if (root_wr) begin
            for (int i = 0; i < N_ENT; i++)
                st_d.ent[i].vld = 1'b0;
            st_d.ptr   = '0;
            st_d.stale = st_d.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            lk_hit,
    input logic [PA_W-1:0] lk_paddr,
    input logic            walk_req,
    input logic            inv_valid,
    input logic [VA_W-1:0] inv_vaddr,
    input logic            root_wr
);
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[PG_SH-1:0] == lk_vaddr[PG_SH-1:0]);

    assert_miss_walks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> walk_req);

    assert_inv_gone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(inv_valid) && lk_vaddr == $past(inv_vaddr)) |-> !lk_hit);

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        root_wr |=> !lk_hit);
endmodule

bind tlb_cache tlb_cache_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_vaddr (lk_vaddr),
    .lk_hit   (lk_hit),
    .lk_paddr (lk_paddr),
    .walk_req (walk_req),
    .inv_valid(inv_valid),
    .inv_vaddr(inv_vaddr),
    .root_wr  (root_wr)
);

// File: tb/tlb_cache_test.sv
module tlb_cache_test;
    import tlb_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lk_valid = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic            lk_hit, lk_wr, lk_usr, lk_nx, walk_req;
    logic [PA_W-1:0] lk_paddr;
    logic            fill_valid = 1'b0;
    logic [VA_W-1:0] fill_vaddr = '0;
    logic [FN_W-1:0] fill_frame = '0;
    logic [1:0]      fill_size = '0;
    logic            fill_wr = 1'b0, fill_usr = 1'b0, fill_nx = 1'b0;
    logic            inv_valid = 1'b0;
    logic [VA_W-1:0] inv_vaddr = '0;
    logic            root_wr = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tlb_cache uut (.*);

    typedef struct packed {
        logic [47:0] va;
        logic        hit;
        logic [39:0] pa;
        logic [2:0]  perm;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{48'h000012345678, 1'b1, 40'h00ABCDE678, 3'b100},
        '{48'h000012345FFF, 1'b1, 40'h00ABCDEFFF, 3'b100},
        '{48'h000012344FFF, 1'b0, 40'h0,          3'b000},
        '{48'h00007F7ABCDE, 1'b1, 40'h00013ABCDE, 3'b111},
        '{48'h00007F800000, 1'b0, 40'h0,          3'b000},
        '{48'h00007F5FFFFF, 1'b0, 40'h0,          3'b000},
        '{48'h7FFFD2345678, 1'b1, 40'h0052345678, 3'b011},
        '{48'h7FFFFFFFFFFF, 1'b1, 40'h007FFFFFFF, 3'b011},
        '{48'h7FFFBFFFFFFF, 1'b0, 40'h0,          3'b000}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with the given fill / maintenance inputs, then idle.
    task automatic step(logic fv, logic [47:0] fva, logic [27:0] ffr, logic [1:0] fsz,
                        logic [2:0] perm, logic iv, logic [47:0] iva, logic rw);
        fill_valid = fv; fill_vaddr = fva; fill_frame = ffr; fill_size = fsz;
        {fill_wr, fill_usr, fill_nx} = perm;
        inv_valid = iv; inv_vaddr = iva; root_wr = rw;
        @(posedge clk); #1;
        fill_valid = 1'b0; inv_valid = 1'b0; root_wr = 1'b0;
    endtask

    task automatic fill(logic [47:0] va, logic [27:0] fr, logic [1:0] sz, logic [2:0] perm);
        step(1'b1, va, fr, sz, perm, 1'b0, 48'h0, 1'b0);
    endtask

    task automatic inval(logic [47:0] va);
        step(1'b0, 48'h0, 28'h0, 2'd0, 3'b000, 1'b1, va, 1'b0);
    endtask

    task automatic flush();
        step(1'b0, 48'h0, 28'h0, 2'd0, 3'b000, 1'b0, 48'h0, 1'b1);
    endtask

    // Miss held across one edge so that a walk becomes outstanding.
    task automatic request(logic [47:0] va);
        lk_valid = 1'b1; lk_vaddr = va;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic look(string req, logic [47:0] va, logic exp_hit);
        lk_valid = 1'b1; lk_vaddr = va;
        #1;
        check(req, {63'h0, lk_hit}, {63'h0, exp_hit});
        lk_valid = 1'b0;
    endtask

    task automatic look_pa(string req, logic [47:0] va, logic [39:0] pa);
        lk_valid = 1'b1; lk_vaddr = va;
        #1;
        check(req, {23'h0, lk_hit, lk_paddr}, {23'h0, 1'b1, pa});
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: empty after reset; R3 walk request on the miss
        lk_valid = 1'b1; lk_vaddr = 48'h000012345678;
        #1;
        check("R10 empty after reset", {63'h0, lk_hit}, 64'h0);
        check("R3 walk on miss", {63'h0, walk_req}, 64'h1);
        lk_valid = 1'b0;
        #1;
        check("R3 no walk when idle", {63'h0, walk_req}, 64'h0);

        // R4: fills of each size (frame low bits set on the larger pages)
        fill(48'h000012345000, 28'h00ABCDE, 2'd0, 3'b100);
        fill(48'h00007F600000, 28'h0001201, 2'd1, 3'b111);
        fill(48'h7FFFC0000000, 28'h0040155, 2'd2, 3'b011);

        // R1 R2 R3: vector walk
        foreach (VECS[i]) begin
            lk_valid = 1'b1; lk_vaddr = VECS[i].va;
            #1;
            check($sformatf("R1 hit vec %0d", i), {63'h0, lk_hit}, {63'h0, VECS[i].hit});
            check($sformatf("R3 walk vec %0d", i), {63'h0, walk_req}, {63'h0, !VECS[i].hit});
            if (VECS[i].hit) begin
                check($sformatf("R2 paddr vec %0d", i), {24'h0, lk_paddr}, {24'h0, VECS[i].pa});
                check($sformatf("R1 perms vec %0d", i), {61'h0, lk_wr, lk_usr, lk_nx},
                      {61'h0, VECS[i].perm});
            end
            lk_valid = 1'b0;
        end

        // R2: reserved size code acts as 4KB
        fill(48'h000055555000, 28'h0000777, 2'd3, 3'b000);
        look_pa("R2 code3 hit", 48'h000055555ABC, 40'h0000777ABC);
        look("R2 code3 next page misses", 48'h000055556000, 1'b0);

        // R5: invalidate only the covering 2MB entry
        inval(48'h00007F712345);
        look("R5 covered entry gone", 48'h00007F7ABCDE, 1'b0);
        look("R5 4KB entry kept", 48'h000012345678, 1'b1);
        look("R5 1GB entry kept", 48'h7FFFD2345678, 1'b1);

        // R6: flush empties everything
        flush();
        look("R6 4KB gone", 48'h000012345678, 1'b0);
        look("R6 1GB gone", 48'h7FFFD2345678, 1'b0);
        look("R6 code3 gone", 48'h000055555ABC, 1'b0);

        // R7: replacement order (pointer at 0 after the flush)
        for (int k = 0; k < 8; k++)
            fill(48'h000010000000 + (48'(k) << 12), 28'h100 + 28'(k), 2'd0, 3'b000);
        fill(48'h000020000000, 28'h200, 2'd0, 3'b000);
        look("R7 full cache evicts pointer entry", 48'h000010000000, 1'b0);
        look("R7 next entry kept", 48'h000010001000, 1'b1);
        inval(48'h000010003000);
        fill(48'h000020001000, 28'h201, 2'd0, 3'b000);
        fill(48'h000020002000, 28'h202, 2'd0, 3'b000);
        look("R7 invalid slot used before valid", 48'h000010001000, 1'b1);
        look("R7 entry kept", 48'h000010002000, 1'b1);
        look("R7 pointer advanced past refilled slot", 48'h000010004000, 1'b0);
        look("R7 entry kept after pointer", 48'h000010005000, 1'b1);
        look_pa("R7 refill stored", 48'h000020001234, 40'h0000201234);
        look_pa("R7 second refill stored", 48'h000020002000, 40'h0000202000);

        // R8: same-cycle maintenance against fills
        flush();
        step(1'b1, 48'h000030000000, 28'h300, 2'd0, 3'b000, 1'b0, 48'h0, 1'b1);
        look("R8 fill dropped by flush", 48'h000030000000, 1'b0);
        step(1'b1, 48'h000031000000, 28'h310, 2'd0, 3'b000, 1'b1, 48'h000031000ABC, 1'b0);
        look("R8 fill dropped by covering invalidate", 48'h000031000000, 1'b0);
        step(1'b1, 48'h000032000000, 28'h320, 2'd0, 3'b000, 1'b1, 48'h000033000000, 1'b0);
        look("R8 fill kept with other invalidate", 48'h000032000000, 1'b1);

        // R9: walk straddling a flush is discarded
        request(48'h000034000000);
        flush();
        fill(48'h000034000000, 28'h340, 2'd0, 3'b000);
        look("R9 stale fill dropped", 48'h000034000000, 1'b0);
        request(48'h000035000000);
        fill(48'h000035000000, 28'h350, 2'd0, 3'b000);
        look("R9 later fill stored", 48'h000035000000, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule